// File: doc/BRIEF.md
# Strap-Sampled Configuration Status Register

This block is a 32-bit read/write configuration register for a platform controller. Its fields sit in two reset domains. A battery-backed domain holds the boot-flash swap bit and the processor frequency multiplier field, and only a real-time-clock reset clears it. A core domain holds the remaining bits and clears on every core reset.

When the power-good input rises, the block samples two strap pins. One pin sets a read-only safe-mode bit. While that bit is set, the multiplier field reads as all ones and software cannot write it. The other pin sets a sticky no-reboot bit that software cannot clear while the strap was sampled high.

The register also drives three side effects:
- It inverts one address bit on boot-flash code cycles.
- It asserts a processor init line while the processor reset input is active, and holds it a fixed number of cycles after reset is released.
- It turns the second consecutive watchdog timeout into a one-cycle reboot request, unless reboot is disabled.

Software reads the register combinationally on `rd_data` and writes it with a single-cycle `wr_en` strobe. Reset release is synchronized inside the block, so each domain starts updating on the third clock edge after its reset input goes high.

Top module: `cfg_strap_status_reg`

## Requirements
- R1: Register layout: bit 13 is swap, bit 12 is init-enable, bits 11:8 are the multiplier, bit 2 is safe mode and bit 1 is no-reboot. Bits 31:14, 7:3 and 0 always read 0. After both resets, and before any power-good rise, `rd_data` reads 0x00000F00.
- R2: Bit 13 is written by software. Core reset leaves it unchanged, and only the real-time-clock reset clears it to 0.
- R3: `flash_addr_out` equals `flash_addr_in` with bit 16 inverted when bit 13 is 1 and `flash_is_code` is 1. In every other case it passes unchanged.
- R4: Bit 12 is written by software and clears on core reset. When it is 1, `cpu_init_out` is high while `cpu_rst_in` is high and stays high for HOLD_CYC (default 4) cycles after `cpu_rst_in` falls. When bit 12 is 0, `cpu_init_out` stays low.
- R5: A write updates bits 11:8 only while bit 2 is 0. Otherwise the write is ignored. The field keeps its value across core reset and reads 4'hF after the real-time-clock reset.
- R6: A power-good rising edge loads bit 2 from `strap_safe_pin`. If that pin is high, bits 11:8 become 4'hF.
- R7: Once bit 2 is 1, it stays 1 while power-good falls. It returns to 0 only on a later power-good rise that samples the pin low, or on core reset.
- R8: A power-good rise with `strap_noboot_pin` high sets bit 1. A software write of 1 also sets it. A write of 0 clears it only if the most recent power-good rise sampled that pin low.
- R9: While bit 1 is 0, the second `wdt_timeout` pulse with no `wdt_reload` in between raises `reboot_req` for exactly one cycle, on the cycle after that pulse. While bit 1 is 1, no request is issued. Every second timeout restarts the count.
- R10: The strap pins are sampled only on the rising edge of power-good. While power-good stays high, pin changes have no effect on bits 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rtc_rst_n | input | 1 | Asynchronous active-low reset of the battery-backed fields |
| core_rst_n | input | 1 | Asynchronous active-low reset of the core fields |
| pwr_good | input | 1 | Power-good level; a rising edge triggers strap sampling |
| strap_safe_pin | input | 1 | Safe-mode strap level |
| strap_noboot_pin | input | 1 | No-reboot strap level |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| cpu_rst_in | input | 1 | Processor reset, active high |
| cpu_init_out | output | 1 | Processor init request, active high |
| flash_is_code | input | 1 | High for boot-flash code-space cycles, low for feature space |
| flash_addr_in | input | 20 | Flash cycle address |
| flash_addr_out | output | 20 | Flash address after the optional swap |
| wdt_timeout | input | 1 | One-cycle watchdog timeout pulse |
| wdt_reload | input | 1 | Watchdog reload; restarts the two-timeout count |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
Every stored bit is visible on `rd_data` in the same cycle it changes, so a wrong field value shows up at the next comparison. This includes a value lost in the wrong reset domain and a strap latched at the wrong time. Wrong hidden state shows up later. A mis-latched no-reboot strap only appears when a later write of 0 fails to clear bit 1. A mis-counted watchdog flag shows as a missing or extra `reboot_req` on the cycle after the second timeout. A wrong hold count shows as `cpu_init_out` falling early or late relative to `cpu_rst_in`.

// File: rtl/cfg_strap_pkg.sv
package cfg_strap_pkg;
  localparam int REG_W     = 32;
  localparam int FREQ_W    = 4;
  localparam int SWAP_POS  = 13;
  localparam int BIST_POS  = 12;
  localparam int FREQ_LSB  = 8;
  localparam int SAFE_POS  = 2;
  localparam int NOBT_POS  = 1;
  typedef logic [FREQ_W-1:0] freq_t;
  localparam freq_t FREQ_SAFE = '1;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_strap_capture.sv
module cfg_strap_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic safe_pin,
  input  logic noboot_pin,
  input  logic wr_en,
  input  logic wr_noboot,
  output logic pg_edge,
  output logic safe_q,
  output logic noboot_q
);
  logic pg_q, pg_qq;
  logic nbstrap_q;
  logic safe_d, nbstrap_d, noboot_d;

  always_comb begin
    pg_edge   = pg_q & ~pg_qq;
    safe_d    = safe_q;
    nbstrap_d = nbstrap_q;
    noboot_d  = noboot_q;
    if (pg_edge) begin
      safe_d    = safe_pin;
      nbstrap_d = noboot_pin;
      noboot_d  = noboot_q | noboot_pin;
    end else if (wr_en) begin
      noboot_d  = wr_noboot | nbstrap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q      <= 1'b0;
      pg_qq     <= 1'b0;
      safe_q    <= 1'b0;
      nbstrap_q <= 1'b0;
      noboot_q  <= 1'b0;
    end else begin
      pg_q      <= pwr_good;
      pg_qq     <= pg_q;
      safe_q    <= safe_d;
      nbstrap_q <= nbstrap_d;
      noboot_q  <= noboot_d;
    end
  end
endmodule

// File: rtl/cfg_rtc_fields.sv
module cfg_rtc_fields
  import cfg_strap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pg_edge,
  input  logic  safe_pin,
  input  logic  safe_q,
  input  logic  wr_en,
  input  logic  wr_swap,
  input  freq_t wr_freq,
  output logic  swap_q,
  output freq_t freq_q
);
  logic  swap_d;
  freq_t freq_d;

  always_comb begin
    swap_d = wr_en ? wr_swap : swap_q;
    freq_d = freq_q;
    if (pg_edge && safe_pin)   freq_d = FREQ_SAFE;
    else if (wr_en && !safe_q) freq_d = wr_freq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q <= 1'b0;
      freq_q <= FREQ_SAFE;
    end else begin
      swap_q <= swap_d;
      freq_q <= freq_d;
    end
  end
endmodule

// File: rtl/cfg_cpu_init_hold.sv
module cfg_cpu_init_hold #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bist,
  input  logic cpu_rst_in,
  output logic bist_q,
  output logic init_out
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYC);

  logic [HW-1:0] hold_q, hold_d;
  logic          bist_d;

  always_comb begin
    bist_d = wr_en ? wr_bist : bist_q;
    hold_d = hold_q;
    if (cpu_rst_in)        hold_d = HOLD_LD;
    else if (hold_q != '0) hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bist_q <= 1'b0;
      hold_q <= '0;
    end else begin
      bist_q <= bist_d;
      hold_q <= hold_d;
    end
  end

  assign init_out = bist_q & (cpu_rst_in | (hold_q != '0));
endmodule

// File: rtl/cfg_wdt_gate.sv
module cfg_wdt_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic reload,
  input  logic noboot,
  output logic reboot_req
);
  logic armed_q, armed_d, reboot_d;

  always_comb begin
    armed_d  = armed_q;
    reboot_d = 1'b0;
    if (timeout) begin
      reboot_d = armed_q & ~noboot;
      armed_d  = ~armed_q;
    end else if (reload) begin
      armed_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      reboot_req <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      reboot_req <= reboot_d;
    end
  end
endmodule

// File: rtl/cfg_strap_status_reg.sv
module cfg_strap_status_reg
  import cfg_strap_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SWAP_ADDR = 16,
  parameter int HOLD_CYC  = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rtc_rst_n,
  input  logic              core_rst_n,
  input  logic              pwr_good,
  input  logic              strap_safe_pin,
  input  logic              strap_noboot_pin,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              cpu_rst_in,
  output logic              cpu_init_out,
  input  logic              flash_is_code,
  input  logic [ADDR_W-1:0] flash_addr_in,
  output logic [ADDR_W-1:0] flash_addr_out,
  input  logic              wdt_timeout,
  input  logic              wdt_reload,
  output logic              reboot_req
);
  localparam logic [ADDR_W-1:0] SWAP_MASK = ADDR_W'(1) << SWAP_ADDR;

  logic  core_srst_n, rtc_srst_n;
  logic  pg_edge, safe_q, noboot_q, swap_q, bist_q;
  freq_t freq_q;
  freq_t freq_view;

  cfg_rst_sync #(.STAGES(SYNC_STG)) u_core_sync (
    .clk(clk), .arst_n(core_rst_n), .srst_n(core_srst_n));

  cfg_rst_sync #(.STAGES(SYNC_STG)) u_rtc_sync (
    .clk(clk), .arst_n(rtc_rst_n), .srst_n(rtc_srst_n));

  cfg_strap_capture u_capture (
    .clk(clk), .rst_n(core_srst_n), .pwr_good(pwr_good),
    .safe_pin(strap_safe_pin), .noboot_pin(strap_noboot_pin),
    .wr_en(wr_en), .wr_noboot(wr_data[NOBT_POS]),
    .pg_edge(pg_edge), .safe_q(safe_q), .noboot_q(noboot_q));

  cfg_rtc_fields u_rtc (
    .clk(clk), .rst_n(rtc_srst_n), .pg_edge(pg_edge),
    .safe_pin(strap_safe_pin), .safe_q(safe_q), .wr_en(wr_en),
    .wr_swap(wr_data[SWAP_POS]),
    .wr_freq(wr_data[FREQ_LSB +: FREQ_W]),
    .swap_q(swap_q), .freq_q(freq_q));

  cfg_cpu_init_hold #(.HOLD_CYC(HOLD_CYC)) u_init (
    .clk(clk), .rst_n(core_srst_n), .wr_en(wr_en),
    .wr_bist(wr_data[BIST_POS]), .cpu_rst_in(cpu_rst_in),
    .bist_q(bist_q), .init_out(cpu_init_out));

  cfg_wdt_gate u_wdt (
    .clk(clk), .rst_n(core_srst_n), .timeout(wdt_timeout),
    .reload(wdt_reload), .noboot(noboot_q), .reboot_req(reboot_req));

  always_comb begin
    freq_view = safe_q ? FREQ_SAFE : freq_q;
    rd_data = '0;
    rd_data[SWAP_POS]               = swap_q;
    rd_data[BIST_POS]               = bist_q;
    rd_data[FREQ_LSB +: FREQ_W]     = freq_view;
    rd_data[SAFE_POS]               = safe_q;
    rd_data[NOBT_POS]               = noboot_q;
  end

  assign flash_addr_out = (swap_q && flash_is_code) ? (flash_addr_in ^ SWAP_MASK)
                                                    : flash_addr_in;
endmodule

// File: rtl/cfg_strap_status_chk.sv
module cfg_strap_status_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rtc_rst_n,
  input logic              core_rst_n,
  input logic              wr_en,
  input logic [31:0]       rd_data,
  input logic              cpu_init_out,
  input logic              flash_is_code,
  input logic [ADDR_W-1:0] flash_addr_in,
  input logic [ADDR_W-1:0] flash_addr_out,
  input logic              reboot_req
);
  // R3
  feature_space_passthru_chk: assert property (@(posedge clk) disable iff (!core_rst_n || !rtc_rst_n)
    !flash_is_code |-> flash_addr_out == flash_addr_in);

  // R4
  init_needs_enable_chk: assert property (@(posedge clk) disable iff (!core_rst_n || !rtc_rst_n)
    cpu_init_out |-> rd_data[12]);

  // R9
  reboot_needs_permit_chk: assert property (@(posedge clk) disable iff (!core_rst_n || !rtc_rst_n)
    reboot_req |-> !$past(rd_data[1]));

  // R9
  reboot_one_cycle_chk: assert property (@(posedge clk) disable iff (!core_rst_n || !rtc_rst_n)
    reboot_req |=> !reboot_req);

  // R2
  swap_holds_chk: assert property (@(posedge clk) disable iff (!core_rst_n || !rtc_rst_n)
    !$past(wr_en) |-> $stable(rd_data[13]));

  // R5
  freq_locked_chk: assert property (@(posedge clk) disable iff (!core_rst_n || !rtc_rst_n)
    (rd_data[2] && $past(rd_data[2])) |-> $stable(rd_data[11:8]));
endmodule

bind cfg_strap_status_reg cfg_strap_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rtc_rst_n(rtc_rst_n), .core_rst_n(core_rst_n), .wr_en(wr_en),
  .rd_data(rd_data), .cpu_init_out(cpu_init_out), .flash_is_code(flash_is_code),
  .flash_addr_in(flash_addr_in), .flash_addr_out(flash_addr_out),
  .reboot_req(reboot_req));

// File: tb/test_cfg_strap_status_reg.sv
`timescale 1ns/1ps
module test_cfg_strap_status_reg;
  localparam int HOLD = 4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rtc_rst_n, core_rst_n, pwr_good, safe_pin, nb_pin, wr_en;
  logic [31:0] wr_data, rd_data;
  logic        cpu_rst_in, cpu_init_out, is_code, wdt_to, wdt_rl, reboot_req;
  logic [19:0] a_in, a_out;

  cfg_strap_status_reg i_cfg_strap_status_reg (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .core_rst_n(core_rst_n), .pwr_good(pwr_good),
    .strap_safe_pin(safe_pin), .strap_noboot_pin(nb_pin), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cpu_rst_in(cpu_rst_in),
    .cpu_init_out(cpu_init_out), .flash_is_code(is_code), .flash_addr_in(a_in),
    .flash_addr_out(a_out), .wdt_timeout(wdt_to), .wdt_reload(wdt_rl),
    .reboot_req(reboot_req));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  core_live = 0, rtc_live = 0;
  bit  m_top, m_bist, m_safe, m_nr, m_nrs, m_pg1, m_pg2, m_armed, m_reboot;
  bit [3:0] m_freq;
  int  m_hold;

  always @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      core_live <= 0; m_bist <= 0; m_safe <= 0; m_nr <= 0; m_nrs <= 0;
      m_pg1 <= 0; m_pg2 <= 0; m_armed <= 0; m_reboot <= 0; m_hold <= 0;
    end else if (core_live < 2) begin
      core_live <= core_live + 1;
    end else begin
      m_pg1 <= pwr_good;
      m_pg2 <= m_pg1;
      if (m_pg1 && !m_pg2) begin
        m_safe <= safe_pin; m_nrs <= nb_pin; m_nr <= m_nr | nb_pin;
      end else if (wr_en) m_nr <= wr_data[1] | m_nrs;
      if (wr_en) m_bist <= wr_data[12];
      if (cpu_rst_in) m_hold <= HOLD;
      else if (m_hold > 0) m_hold <= m_hold - 1;
      if (wdt_to) begin
        m_reboot <= m_armed && !m_nr; m_armed <= !m_armed;
      end else begin
        m_reboot <= 0;
        if (wdt_rl) m_armed <= 0;
      end
    end
  end

  always @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      rtc_live <= 0; m_top <= 0; m_freq <= 4'hF;
    end else if (rtc_live < 2) begin
      rtc_live <= rtc_live + 1;
    end else begin
      if (wr_en) m_top <= wr_data[13];
      if (m_pg1 && !m_pg2 && safe_pin) m_freq <= 4'hF;
      else if (wr_en && !m_safe) m_freq <= wr_data[11:8];
    end
  end

  always @(negedge clk) if (!done) begin
    logic [3:0] ef;
    logic [19:0] ea;
    ef = m_safe ? 4'hF : m_freq;
    ea = (m_top && is_code) ? (a_in ^ 20'h10000) : a_in;
    chk(rd_data[31:14] == 0 && rd_data[7:3] == 0 && rd_data[0] == 0, "R1 reserved", rd_data, rd_data & 32'h3F06);
    chk(rd_data[13] == m_top, "R2 swap bit", rd_data[13], m_top);
    chk(a_out == ea, "R3 flash addr", a_out, ea);
    chk(cpu_init_out == (m_bist && (cpu_rst_in || m_hold != 0)), "R4 init", cpu_init_out,
        m_bist && (cpu_rst_in || m_hold != 0));
    chk(rd_data[12] == m_bist, "R4 enable bit", rd_data[12], m_bist);
    chk(rd_data[11:8] == ef, "R5 multiplier", rd_data[11:8], ef);
    chk(rd_data[2] == m_safe, "R6 safe bit", rd_data[2], m_safe);
    chk(rd_data[1] == m_nr, "R8 no-reboot bit", rd_data[1], m_nr);
    chk(reboot_req == m_reboot, "R9 reboot", reboot_req, m_reboot);
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask
  task automatic wr(input logic [31:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = 0; tick();
  endtask
  task automatic pg_rise(input bit s, input bit n);
    safe_pin = s; nb_pin = n; pwr_good = 1; tick(4);
  endtask
  task automatic timeout_pulse();
    wdt_to = 1; tick(); wdt_to = 0;
  endtask
  task automatic sample(input logic [31:0] exp, input string req);
    @(negedge clk); chk(rd_data == exp, req, rd_data, exp); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rtc_rst_n = 0; core_rst_n = 0; pwr_good = 0; safe_pin = 0; nb_pin = 0;
    wr_en = 0; wr_data = 0; cpu_rst_in = 0; is_code = 0; a_in = 0; wdt_to = 0; wdt_rl = 0;
    tick(4); rtc_rst_n = 1; core_rst_n = 1; tick(4);
    sample(32'h0000_0F00, "R1 reset value");
    wr(32'hFFFF_FFFF);
    sample(32'h0000_3F02, "R1 all-ones write");
    wr(32'h0000_0500);
    sample(32'h0000_0500, "R8 clear with strap low / R5 write");
    pg_rise(0, 0);
    wr(32'h0000_3A00);
    sample(32'h0000_3A00, "R5 write while safe=0");
    // R3 flash address patterns
    is_code = 1; a_in = 20'h12345; tick(2);
    @(negedge clk); chk(a_out == 20'h02345, "R3 code space", a_out, 20'h02345); tick();
    a_in = 20'h0ABCD; tick(2);
    is_code = 0; a_in = 20'h1F00F; tick(2);
    @(negedge clk); chk(a_out == 20'h1F00F, "R3 feature space", a_out, 20'h1F00F); tick();
    // R4 init hold
    cpu_rst_in = 1; tick(3); cpu_rst_in = 0; tick(HOLD + 3);
    @(negedge clk); chk(cpu_init_out == 0, "R4 init released", cpu_init_out, 0); tick();
    wr(32'h0000_2A00);
    cpu_rst_in = 1; tick(3); cpu_rst_in = 0; tick(HOLD + 2);
    // R9 watchdog
    timeout_pulse(); tick(2); timeout_pulse();
    @(negedge clk); chk(reboot_req == 1, "R9 second timeout", reboot_req, 1); tick(2);
    timeout_pulse(); wdt_rl = 1; tick(); wdt_rl = 0; timeout_pulse(); tick(3);
    timeout_pulse(); tick(3);
    // R2 / R5 retention across core reset
    core_rst_n = 0; tick(3); core_rst_n = 1; tick(4);
    sample(32'h0000_2A00, "R2 R5 retained over core reset");
    // R6 / R8 strap high
    pwr_good = 0; tick(2);
    pg_rise(1, 1);
    sample(32'h0000_2F06, "R6 safe strap / R8 strap set");
    wr(32'h0000_0300);
    sample(32'h0000_0F06, "R5 write blocked / R8 clear blocked");
    timeout_pulse(); tick(); timeout_pulse(); tick(3);
    // R10 pins ignored while power-good held
    safe_pin = 0; nb_pin = 0; tick(5);
    sample(32'h0000_0F06, "R10 no resample while high");
    pwr_good = 0; tick(4);
    sample(32'h0000_0F06, "R7 safe holds while power-good low");
    pg_rise(0, 0);
    sample(32'h0000_0F02, "R7 safe cleared by low sample");
    wr(32'h0000_0700);
    sample(32'h0000_0700, "R8 clear after low strap / R5 writable");
    rtc_rst_n = 0; tick(3); rtc_rst_n = 1; tick(4);
    sample(32'h0000_0F00, "R2 R5 rtc reset");
    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule